// File: doc/BRIEF.md
# T1 Extended Superframe Transmit Framer

This block formats an outgoing T1 bit stream into a 24-frame extended superframe. Each frame is one framing bit followed by a parameterised number of payload bits (192 by default). The framer takes one line bit per clock, registers it and sends it on. On the framing-bit slot it may replace the incoming bit. Across the superframe the framing bits take three roles. Frames 4, 8, 12, 16, 20 and 24 carry the alignment word. Frames 2, 6, 10, 14, 18 and 22 carry a CRC-6. The twelve odd frames carry the facility data link.

The CRC is accumulated over every transmitted bit of one superframe and sent in the CRC slots of the next one. It can be inverted for testing or left untouched. The data-link slot is filled by a fixed-priority choice. Yellow alarm has the highest priority, then three external message sources (bit-oriented code, performance report, HDLC), and idle code last. A registered one-hot strobe tells a source that its bit went out. The strobe is aligned with the line bit that carried it. Two diagnostic aids are provided: a copy of each framing bit into the following slot, and a whole-framing bypass.

Top module: `esf_tx_framer`

## Requirements
- R1: While `rst_n` is low, `line_out`, `sf_sync` and `dl_take` are 0. After release, the first input bit is the framing slot of frame 1. Each output bit appears one clock after its input bit.
- R2: With `fdis` clear, the framing bits of frames 4, 8, 12, 16, 20, 24 carry 0, 0, 1, 0, 1, 1 in that frame order.
- R3: With `fdis`, `crc_byp` and `crc_inv` clear, the framing bits of frames 2, 6, 10, 14, 18, 22 carry CRC bits c5 down to c0 of the previous superframe. The CRC uses x^6+x+1, starts at zero and shifts in every transmitted bit, with framing slots counted as 1. In the first superframe after reset these slots carry 0.
- R4: `crc_inv` inverts all six CRC slots. `crc_byp` leaves the CRC slots equal to the input bit.
- R5: `fs_inv` inverts only the alignment bit of frame 4.
- R6: Data-link priority is yellow, then `dl_req[0]`, then `dl_req[1]`, then `dl_req[2]`, then idle. The winning source's `dl_bit` is sent. `dl_take[i]` is high with the `line_out` bit that carried source i's bit, and at most one `dl_take` bit is high.
- R7: Yellow is active when `yel_send` is set, or when both `yel_auto` and `rx_red` are set. It sends pattern 0xFF00 when `j1_mode` is 0 and 0xFFFF when it is 1, in the data-link slots, whatever the value of `dl_byp`.
- R8: Idle sends 0xFFFF when `j1_mode` is 0 and 0xFF7E when it is 1. Both 16-bit patterns are sent MSB first. The bit index is the count of data-link slots since reset, modulo 16, counted even while `fdis` is set.
- R9: With `dl_byp` set and no yellow, the data-link slots carry the input bit, `dl_req` and `dl_bit` have no effect, and `dl_take` stays 0.
- R10: With `mimic_en` set and `fdis` clear, the bit after each framing bit equals the transmitted framing bit.
- R11: With `fdis` set, `line_out` equals the input bit of the previous clock and `dl_take` stays 0. The CRC keeps accumulating over the bits sent.
- R12: Payload bits pass unchanged. `sf_sync` is high together with the framing bit of frame 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Incoming line bit, framing slot included |
| fdis | input | 1 | Framing disable, pass all bits through |
| crc_byp | input | 1 | Leave CRC slots as received |
| crc_inv | input | 1 | Invert the six CRC bits |
| fs_inv | input | 1 | Invert the frame-4 alignment bit |
| mimic_en | input | 1 | Copy each framing bit into the next slot |
| j1_mode | input | 1 | Select J1 yellow and idle patterns |
| yel_send | input | 1 | Send yellow alarm |
| yel_auto | input | 1 | Send yellow automatically while red is seen |
| rx_red | input | 1 | Red alarm from receive side |
| dl_byp | input | 1 | Disable the message sources and idle code |
| dl_req | input | 3 | Source requests: 0 bit-oriented code, 1 report, 2 HDLC |
| dl_bit | input | 3 | Current data bit of each source |
| line_out | output | 1 | Framed line bit |
| sf_sync | output | 1 | Marks the frame-1 framing bit on `line_out` |
| dl_take | output | 3 | One-hot: source whose bit was sent |

## Verification
The stream is random payload, so any slip in the frame position shows up in the payload comparison. The CRC slots are only meaningful if the framing bits are counted as 1 and the previous superframe is used. Request sets are tried in turn: all three sources together, the lower two, HDLC alone, and none. These show the order of priority and which source gets the strobe. Yellow is tried manually, automatically, with auto set but no red, and under data-link bypass. T1 and J1 runs separate the pattern pairs, and the slot count carried across superframe edges shows the pattern wraps. Further superframes turn on CRC inversion, CRC bypass, alignment inversion, mimic and full framing bypass. One normal superframe follows the bypass so that the CRC over the passed-through bits is checked.

// File: rtl/esf_pkg.sv
package esf_pkg;
   typedef enum logic [1:0] {
      SLOT_PAY = 2'd0,
      SLOT_FAS = 2'd1,
      SLOT_CRC = 2'd2,
      SLOT_DL  = 2'd3
   } slot_role_t;
endpackage

// File: rtl/esf_pos_counter.sv
module esf_pos_counter
   import esf_pkg::*;
#(
   parameter int FRAME_LEN = 193,
   parameter int FRAMES    = 24
) (
   input  logic                       clk,
   input  logic                       rst_n,
   output slot_role_t                 role,
   output logic [$clog2(FRAMES)-3:0]  grp,
   output logic                       is_mimic,
   output logic                       is_first,
   output logic                       sf_end
);
   localparam int BIT_W = $clog2(FRAME_LEN);
   localparam int FRM_W = $clog2(FRAMES);

   generate
      if (FRAMES % 4 != 0 || FRAMES < 8) begin : g_bad_frames
         $error("FRAMES must be a multiple of 4, at least 8");
      end
      if (FRAME_LEN < 3) begin : g_bad_len
         $error("FRAME_LEN too short");
      end
   endgenerate

   logic [BIT_W-1:0] bit_idx;
   logic [FRM_W-1:0] frm_idx;
   logic             end_frame;

   assign end_frame = (bit_idx == BIT_W'(FRAME_LEN - 1));
   assign sf_end    = end_frame && (frm_idx == FRM_W'(FRAMES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx <= '0;
         frm_idx <= '0;
      end else if (end_frame) begin
         bit_idx <= '0;
         frm_idx <= sf_end ? '0 : frm_idx + 1'b1;
      end else begin
         bit_idx <= bit_idx + 1'b1;
      end
   end

   // frame number = frm_idx + 1; odd frames -> data link
   always_comb begin
      role = SLOT_PAY;
      if (bit_idx == '0) begin
         unique case (frm_idx[1:0])
            2'd0, 2'd2: role = SLOT_DL;
            2'd1:       role = SLOT_CRC;
            default:    role = SLOT_FAS;
         endcase
      end
   end

   assign grp      = frm_idx[FRM_W-1:2];
   assign is_mimic = (bit_idx == BIT_W'(1));
   assign is_first = (bit_idx == '0) && (frm_idx == '0);

   assert_pos_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_idx < BIT_W'(FRAME_LEN)) && (frm_idx < FRM_W'(FRAMES)));

   assert_sf_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sf_end |=> is_first);
endmodule

// File: rtl/esf_crc_acc.sv
module esf_crc_acc #(
   parameter int          CRC_W = 6,
   parameter logic [CRC_W-1:0] POLY = 6'h03
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic             is_f,
   input  logic             sf_end,
   output logic [CRC_W-1:0] hold
);
   generate
      if (CRC_W < 2) begin : g_bad_w
         $error("CRC_W must be at least 2");
      end
   endgenerate

   logic [CRC_W-1:0] acc, nxt;
   logic             d_eff, fb;

   assign d_eff = is_f | din;
   assign fb    = acc[CRC_W-1] ^ d_eff;
   assign nxt   = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         hold <= '0;
      end else if (sf_end) begin
         acc  <= '0;
         hold <= nxt;
      end else begin
         acc  <= nxt;
      end
   end

   assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !sf_end |=> $stable(hold));
endmodule

// File: rtl/esf_dl_arb.sv
module esf_dl_arb #(
   parameter int              N_SRC     = 3,
   parameter int              PAT_W     = 16,
   parameter logic [PAT_W-1:0] YEL_T1   = 16'hFF00,
   parameter logic [PAT_W-1:0] YEL_J1   = 16'hFFFF,
   parameter logic [PAT_W-1:0] IDLE_T1  = 16'hFFFF,
   parameter logic [PAT_W-1:0] IDLE_J1  = 16'hFF7E
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dl_slot,
   input  logic             j1_mode,
   input  logic             yel_on,
   input  logic             byp,
   input  logic             fdis,
   input  logic             slot_in,
   input  logic [N_SRC-1:0] req,
   input  logic [N_SRC-1:0] bits,
   output logic             dl_out,
   output logic [N_SRC-1:0] take
);
   localparam int PTR_W = $clog2(PAT_W);

   generate
      if ((1 << PTR_W) != PAT_W) begin : g_bad_pat
         $error("PAT_W must be a power of two");
      end
   endgenerate

   logic [PTR_W-1:0] ptr, idx;
   logic [N_SRC:0]   blocked;
   logic [PAT_W-1:0] yel_pat, idle_pat;

   assign idx      = ~ptr;
   assign yel_pat  = j1_mode ? YEL_J1 : YEL_T1;
   assign idle_pat = j1_mode ? IDLE_J1 : IDLE_T1;

   assign blocked[0] = ~(dl_slot & ~fdis & ~yel_on & ~byp);
   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_prio
         assign take[g]      = req[g] & ~blocked[g];
         assign blocked[g+1] = blocked[g] | req[g];
      end
   endgenerate

   always_comb begin
      if (yel_on)       dl_out = yel_pat[idx];
      else if (byp)     dl_out = slot_in;
      else if (|take)   dl_out = |(take & bits);
      else              dl_out = idle_pat[idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (dl_slot) ptr <= ptr + 1'b1;
   end

   assert_take_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take));

   assert_yel_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      yel_on |-> (take == '0));
endmodule

// File: rtl/esf_tx_framer.sv
module esf_tx_framer
   import esf_pkg::*;
#(
   parameter int PAYLOAD_BITS = 192,
   parameter int FRAMES       = 24,
   parameter int CRC_W        = 6,
   parameter int N_SRC        = 3,
   parameter logic [CRC_W-1:0] FAS_PAT = 6'b001011,
   parameter int FS_INV_GRP   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_in,
   input  logic             fdis,
   input  logic             crc_byp,
   input  logic             crc_inv,
   input  logic             fs_inv,
   input  logic             mimic_en,
   input  logic             j1_mode,
   input  logic             yel_send,
   input  logic             yel_auto,
   input  logic             rx_red,
   input  logic             dl_byp,
   input  logic [N_SRC-1:0] dl_req,
   input  logic [N_SRC-1:0] dl_bit,
   output logic             line_out,
   output logic             sf_sync,
   output logic [N_SRC-1:0] dl_take
);
   localparam int FRAME_LEN = PAYLOAD_BITS + 1;
   localparam int GRP_W     = $clog2(FRAMES) - 2;

   generate
      if (FRAMES != 4 * CRC_W) begin : g_bad_geom
         $error("FRAMES must equal 4*CRC_W");
      end
      if (FS_INV_GRP < 0 || FS_INV_GRP >= CRC_W) begin : g_bad_inv
         $error("FS_INV_GRP out of range");
      end
   endgenerate

   slot_role_t        role;
   logic [GRP_W-1:0]  grp;
   logic              is_mimic, is_first, sf_end;
   logic [CRC_W-1:0]  crc_hold;
   logic              yel_on, dl_val, f_val, out_nxt, f_q;
   logic [N_SRC-1:0]  take_c;
   logic [GRP_W-1:0]  sel;

   esf_pos_counter #(.FRAME_LEN(FRAME_LEN), .FRAMES(FRAMES)) u_pos (
      .clk(clk), .rst_n(rst_n), .role(role), .grp(grp),
      .is_mimic(is_mimic), .is_first(is_first), .sf_end(sf_end));

   esf_crc_acc #(.CRC_W(CRC_W)) u_crc (
      .clk(clk), .rst_n(rst_n), .din(out_nxt), .is_f(role != SLOT_PAY),
      .sf_end(sf_end), .hold(crc_hold));

   assign yel_on = yel_send | (yel_auto & rx_red);

   esf_dl_arb #(.N_SRC(N_SRC)) u_arb (
      .clk(clk), .rst_n(rst_n), .dl_slot(role == SLOT_DL), .j1_mode(j1_mode),
      .yel_on(yel_on), .byp(dl_byp), .fdis(fdis), .slot_in(ser_in),
      .req(dl_req), .bits(dl_bit), .dl_out(dl_val), .take(take_c));

   // first transmitted word bit sits at the MSB
   assign sel = GRP_W'(CRC_W - 1) - grp;

   always_comb begin
      unique case (role)
         SLOT_FAS: f_val = FAS_PAT[sel] ^ (fs_inv && (grp == GRP_W'(FS_INV_GRP)));
         SLOT_CRC: f_val = crc_byp ? ser_in : (crc_hold[sel] ^ crc_inv);
         SLOT_DL:  f_val = dl_val;
         default:  f_val = ser_in;
      endcase
      if (fdis)                       out_nxt = ser_in;
      else if (role != SLOT_PAY)      out_nxt = f_val;
      else if (is_mimic && mimic_en)  out_nxt = f_q;
      else                            out_nxt = ser_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_out <= 1'b0;
         sf_sync  <= 1'b0;
         dl_take  <= '0;
         f_q      <= 1'b0;
      end else begin
         line_out <= out_nxt;
         sf_sync  <= is_first;
         dl_take  <= take_c;
         if (role != SLOT_PAY) f_q <= out_nxt;
      end
   end

   assert_fdis_passthru_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fdis |=> (line_out == $past(ser_in)));

   assert_mimic_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mimic && mimic_en && !fdis) |=> (line_out == $past(line_out)));

   assert_byp_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dl_byp || fdis) |=> (dl_take == '0));
endmodule

// File: tb/test_esf_tx_framer.sv
module test_esf_tx_framer;
   localparam int PL     = 192;
   localparam int FLEN   = PL + 1;
   localparam int NFRM   = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_in = 1'b0, fdis = 1'b0, crc_byp = 1'b0, crc_inv = 1'b0, fs_inv = 1'b0;
   logic mimic_en = 1'b0, j1_mode = 1'b0, yel_send = 1'b0, yel_auto = 1'b0;
   logic rx_red = 1'b0, dl_byp = 1'b0;
   logic [2:0] dl_req = '0, dl_bit = '0;
   logic line_out, sf_sync;
   logic [2:0] dl_take;

   always #4 clk = ~clk;

   esf_tx_framer i_esf_tx_framer (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .fdis(fdis), .crc_byp(crc_byp),
      .crc_inv(crc_inv), .fs_inv(fs_inv), .mimic_en(mimic_en), .j1_mode(j1_mode),
      .yel_send(yel_send), .yel_auto(yel_auto), .rx_red(rx_red), .dl_byp(dl_byp),
      .dl_req(dl_req), .dl_bit(dl_bit), .line_out(line_out), .sf_sync(sf_sync),
      .dl_take(dl_take));

   typedef struct {
      logic       d;
      logic       s;
      logic [2:0] t;
      string      tag;
   } exp_t;
   exp_t q[$];

   int total = 0;
   int bad = 0;

   // bench model state
   int bi = 0, fi = 0, dlc = 0;
   logic [5:0] m_acc = '0, m_hold = '0;
   logic m_flast = 1'b0;
   localparam logic [5:0] FASP = 6'b001011;

   task automatic push_bit();
      exp_t e;
      int n;
      logic o, yel, d_eff, fb;
      logic [15:0] ypat, ipat;
      int k, idx;
      ser_in = 1'($urandom);
      dl_bit = 3'($urandom);
      n = fi + 1;
      e.t = '0;
      e.tag = "R12";
      o = ser_in;
      yel = yel_send | (yel_auto & rx_red);
      ypat = j1_mode ? 16'hFFFF : 16'hFF00;
      ipat = j1_mode ? 16'hFF7E : 16'hFFFF;
      idx = 15 - (dlc % 16);
      if (fdis) begin
         o = ser_in; e.tag = "R11";
      end else if (bi == 0) begin
         if (n % 4 == 0) begin
            k = n / 4 - 1;
            o = FASP[5-k] ^ (fs_inv && k == 0);
            e.tag = fs_inv ? "R5" : "R2";
         end else if (n % 4 == 2) begin
            k = (n - 2) / 4;
            o = crc_byp ? ser_in : (m_hold[5-k] ^ crc_inv);
            e.tag = (crc_byp || crc_inv) ? "R4" : "R3";
         end else if (yel) begin
            o = ypat[idx]; e.tag = "R7";
         end else if (dl_byp) begin
            o = ser_in; e.tag = "R9";
         end else if (dl_req[0]) begin
            o = dl_bit[0]; e.t = 3'b001; e.tag = "R6";
         end else if (dl_req[1]) begin
            o = dl_bit[1]; e.t = 3'b010; e.tag = "R6";
         end else if (dl_req[2]) begin
            o = dl_bit[2]; e.t = 3'b100; e.tag = "R6";
         end else begin
            o = ipat[idx]; e.tag = "R8";
         end
      end else if (bi == 1 && mimic_en) begin
         o = m_flast; e.tag = "R10";
      end
      e.d = o;
      e.s = (bi == 0 && fi == 0);
      q.push_back(e);
      // model update
      if (bi == 0) m_flast = o;
      if (bi == 0 && (n % 2 == 1)) dlc++;
      d_eff = (bi == 0) ? 1'b1 : o;
      fb = m_acc[5] ^ d_eff;
      m_acc = {m_acc[4:0], 1'b0} ^ (fb ? 6'h03 : 6'h00);
      if (bi == FLEN - 1 && fi == NFRM - 1) begin
         m_hold = m_acc;
         m_acc = '0;
      end
      if (bi == FLEN - 1) begin
         bi = 0;
         fi = (fi == NFRM - 1) ? 0 : fi + 1;
      end else begin
         bi++;
      end
      @(negedge clk);
   endtask

   task automatic run_sf(input int cnt);
      for (int s = 0; s < cnt; s++)
         for (int b = 0; b < FLEN * NFRM; b++) push_bit();
   endtask

   task automatic set_ctrl(input logic f, input logic cb, input logic ci,
                           input logic fi_, input logic mi, input logic j1,
                           input logic ys, input logic ya, input logic rr,
                           input logic db, input logic [2:0] rq);
      fdis = f; crc_byp = cb; crc_inv = ci; fs_inv = fi_; mimic_en = mi;
      j1_mode = j1; yel_send = ys; yel_auto = ya; rx_red = rr; dl_byp = db;
      dl_req = rq;
   endtask

   // monitor: compares outputs one cycle after the bit was driven
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (line_out !== e.d || sf_sync !== e.s || dl_take !== e.t) begin
            bad++;
            if (line_out !== e.d)
               $display("FAIL %s line_out act=%b exp=%b", e.tag, line_out, e.d);
            if (sf_sync !== e.s)
               $display("FAIL R12 sf_sync act=%b exp=%b", sf_sync, e.s);
            if (dl_take !== e.t)
               $display("FAIL R6 dl_take act=%b exp=%b", dl_take, e.t);
         end
      end
   end

   initial begin
      #(1_500_000);
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      total++;
      if (line_out !== 1'b0 || sf_sync !== 1'b0 || dl_take !== 3'b000) begin
         bad++;
         $display("FAIL R1 reset outputs act=%b%b%b exp=000", line_out, sf_sync, dl_take);
      end
      rst_n = 1'b1;
      // R1/R2/R3/R8: plain T1, idle, first CRC zero then live
      set_ctrl(0,0,0,0,0,0, 0,0,0, 0, 3'b000); run_sf(2);
      // R6: priority across request sets
      set_ctrl(0,0,0,0,0,0, 0,0,0, 0, 3'b111); run_sf(1);
      set_ctrl(0,0,0,0,0,0, 0,0,0, 0, 3'b110); run_sf(1);
      set_ctrl(0,0,0,0,0,0, 0,0,0, 0, 3'b100); run_sf(1);
      // R7: manual yellow over sources, auto yellow under bypass, auto without red
      set_ctrl(0,0,0,0,0,0, 1,0,0, 0, 3'b111); run_sf(1);
      set_ctrl(0,0,0,0,0,0, 0,1,1, 1, 3'b001); run_sf(1);
      set_ctrl(0,0,0,0,0,0, 0,1,0, 0, 3'b000); run_sf(1);
      // R7/R8 J1 patterns
      set_ctrl(0,0,0,0,0,1, 0,0,0, 0, 3'b000); run_sf(1);
      set_ctrl(0,0,0,0,0,1, 1,0,0, 0, 3'b000); run_sf(1);
      // R9: bypass ignores requests
      set_ctrl(0,0,0,0,0,0, 0,0,0, 1, 3'b111); run_sf(1);
      // R4: inversion and bypass of CRC
      set_ctrl(0,0,1,0,0,0, 0,0,0, 0, 3'b000); run_sf(1);
      set_ctrl(0,1,0,0,0,0, 0,0,0, 0, 3'b000); run_sf(1);
      // R5: single alignment bit inverted
      set_ctrl(0,0,0,1,0,0, 0,0,0, 0, 3'b000); run_sf(1);
      // R10: mimic
      set_ctrl(0,0,0,0,1,0, 0,0,0, 0, 3'b100); run_sf(1);
      // R11: framing disable, then normal to check CRC of passed bits
      set_ctrl(1,0,0,0,1,0, 1,0,0, 0, 3'b111); run_sf(1);
      set_ctrl(0,0,0,0,0,0, 0,0,0, 0, 3'b000); run_sf(1);
      @(negedge clk);
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule